// File: doc/BRIEF.md
# Three-Wire Register Slave with Latched Supply and Fault Status

This block is the device side of a host-clocked three-wire serial register bus on a television signal processor. The host lowers an active-low enable, then clocks in a 16-bit command frame on the shared data line: a chip address, a register index and a 7-bit value. The slave then turns the data line around and clocks back a 16-bit reply. The reply holds a fixed acknowledge pattern, four status flags and an 8-bit fine-tuning value. Commands with a matching address write a 32-entry register file. Other logic on the chip reads that file through a combinational read port.

Two of the status flags are latches whose clear rules depend on the on/off bit, which is bit 0 of register 0. The standby-supply flag sets when the standby-low comparator fires and clears only when the on/off bit goes from OFF to ON. The X-ray fault flag can set only while the set is ON, and clears as soon as the bit goes OFF. The horizontal-drive and PWM enables go high only when the set is ON and both latches are clear.

All bus and comparator inputs are synchronized into the system clock domain. Bus clock edges are detected there. The data line is modelled as an input, an output and an output-enable.

Top module: `tvreg_slave`

## Requirements
- R1: A command frame is sent after enable goes low. Bits are taken on bus clock rising edges, most significant bit first, as 4 address bits, then 5 index bits, then 7 value bits. With a matching address, the value is stored in the register at that index after the 16th bit and is then visible on the read port.
- R2: If the 4 address bits differ from the slave's address, nothing is written and the slave never enables its data output during that transaction.
- R3: The reply is 16 bits, sent most significant bit first: 1,0,1,0, then the standby flag, the X-ray flag, the horizontal-lock input and a constant 0, then the fine-tuning byte (most significant bit first). The flags are the values held when the command frame completes.
- R4: The data output is enabled only in the reply phase. It turns on at the first bus clock falling edge after the 16th command bit. Each reply bit changes on a falling edge. The output is released after the 16th reply rising edge.
- R5: If enable goes high before the 16th command bit, the partial command is discarded. If enable goes high at any point, the data output is released.
- R6: All registers reset to 0. Bit 0 of register 0 is the on/off bit, with 1 meaning ON.
- R7: The standby flag is 1 after reset. It sets whenever standby-low is asserted and clears only on an OFF-to-ON change of the on/off bit. If standby-low is still asserted during that change, the flag stays set.
- R8: The X-ray flag sets on a fault input only while ON. It clears when the on/off bit goes OFF and cannot set while OFF.
- R9: The horizontal-drive and PWM enables are high only while ON and with both flags clear.
- R10: After reset, the data output enable and both drive enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Serial bus clock from the host |
| bus_en_n | input | 1 | Active-low transaction enable |
| bus_dat_i | input | 1 | Data line as seen by the slave |
| bus_dat_o | output | 1 | Data value the slave drives |
| bus_dat_oe_o | output | 1 | Data line drive enable |
| stby_low_i | input | 1 | Standby supply low comparator |
| xray_trip_i | input | 1 | X-ray protection comparator |
| hlock_i | input | 1 | Horizontal lock detector |
| fine_tune_i | input | 8 | Digital fine-tuning value for the reply |
| reg_rd_addr_i | input | 5 | Register file read index |
| reg_rd_data_o | output | 7 | Register file read value |
| hdrv_en_o | output | 1 | Horizontal drive enable |
| pwm_en_o | output | 1 | Supply PWM enable |

## Verification
Two events can arrive in the same system clock cycle. One is a change of the on/off bit, from a completed command to register 0. The other is a comparator event on the standby-low or X-ray input. The bench holds standby-low asserted across an OFF-then-ON command pair and expects the standby flag to remain set and the drive enables to remain low. It also pulses the X-ray input while OFF and expects the flag to read back 0 in the next reply. Each case is judged from the status bits of a later reply and from the enable outputs. No internal state is read.

// File: rtl/tvreg_pkg.sv
package tvreg_pkg;
    localparam int ADDR_W   = 4;
    localparam int SUB_W    = 5;
    localparam int DATA_W   = 7;
    localparam int ACK_W    = 4;
    localparam int STAT_W   = 4;
    localparam int TUNE_W   = 8;
    localparam int WR_BITS  = ADDR_W + SUB_W + DATA_W;
    localparam int RD_BITS  = ACK_W + STAT_W + TUNE_W;
    localparam int NREGS    = 1 << SUB_W;
    localparam int CNT_W    = $clog2(WR_BITS) + 1;
    localparam logic [ACK_W-1:0] ACK_PATTERN = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WRITE,
        PH_SKIP,
        PH_READ,
        PH_DONE
    } phase_e;
endpackage

// File: rtl/tvreg_sync.sv
module tvreg_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tvreg_frame.sv
module tvreg_frame
    import tvreg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CHIP_ADDR = 4'h6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_act_i,
    input  logic               bclk_i,
    input  logic               din_i,
    input  logic [RD_BITS-1:0] reply_i,
    output logic               wr_stb_o,
    output logic [SUB_W-1:0]   wr_sub_o,
    output logic [DATA_W-1:0]  wr_data_o,
    output logic               dout_o,
    output logic               doe_o,
    output logic               fall_o
);
    typedef struct packed {
        phase_e             ph;
        logic               clk_prev;
        logic [CNT_W-1:0]   cnt;
        logic [WR_BITS-1:0] sh;
        logic [RD_BITS-1:0] reply;
        logic               dout;
        logic               doe;
        logic               wr_stb;
    } frame_t;

    frame_t fr_d, fr_q;
    logic   rise, fall;

    assign rise = bclk_i & ~fr_q.clk_prev;
    assign fall = ~bclk_i & fr_q.clk_prev;

    always_comb begin
        fr_d          = fr_q;
        fr_d.clk_prev = bclk_i;
        fr_d.wr_stb   = 1'b0;
        if (!en_act_i) begin
            fr_d.ph   = PH_IDLE;
            fr_d.doe  = 1'b0;
            fr_d.dout = 1'b0;
        end else begin
            unique case (fr_q.ph)
                PH_IDLE: begin
                    fr_d.ph  = PH_WRITE;
                    fr_d.cnt = '0;
                    fr_d.sh  = '0;
                end
                PH_WRITE: begin
                    if (rise) begin
                        fr_d.sh  = {fr_q.sh[WR_BITS-2:0], din_i};
                        fr_d.cnt = fr_q.cnt + 1'b1;
                        if (fr_q.cnt == CNT_W'(ADDR_W - 1) &&
                            {fr_q.sh[ADDR_W-2:0], din_i} != CHIP_ADDR) begin
                            fr_d.ph = PH_SKIP;
                        end else if (fr_q.cnt == CNT_W'(WR_BITS - 1)) begin
                            fr_d.wr_stb = 1'b1;
                            fr_d.ph     = PH_READ;
                            fr_d.reply  = reply_i;
                            fr_d.cnt    = '0;
                        end
                    end
                end
                PH_READ: begin
                    if (fall) begin
                        fr_d.dout  = fr_q.reply[RD_BITS-1];
                        fr_d.reply = {fr_q.reply[RD_BITS-2:0], 1'b0};
                        fr_d.doe   = 1'b1;
                    end
                    if (rise) begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                        if (fr_q.cnt == CNT_W'(RD_BITS - 1)) begin
                            fr_d.ph  = PH_DONE;
                            fr_d.doe = 1'b0;
                        end
                    end
                end
                default: begin
                    fr_d.doe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign wr_stb_o  = fr_q.wr_stb;
    assign wr_sub_o  = fr_q.sh[DATA_W +: SUB_W];
    assign wr_data_o = fr_q.sh[DATA_W-1:0];
    assign dout_o    = fr_q.dout;
    assign doe_o     = fr_q.doe;
    assign fall_o    = fall;
endmodule

// File: rtl/tvreg_status.sv
module tvreg_status (
    input  logic clk,
    input  logic rst_n,
    input  logic onoff_i,
    input  logic stby_i,
    input  logic xray_i,
    output logic por_o,
    output logic xrp_o
);
    typedef struct packed {
        logic por;
        logic xrp;
        logic on_prev;
    } stat_t;

    stat_t st_d, st_q;
    logic  turn_on;

    assign turn_on = onoff_i & ~st_q.on_prev;

    always_comb begin
        st_d         = st_q;
        st_d.on_prev = onoff_i;
        // a standby event outranks the clear from a turn-on in the same cycle
        st_d.por     = stby_i | (st_q.por & ~turn_on);
        // held clear whenever the on/off bit is OFF
        st_d.xrp     = onoff_i & (st_q.xrp | xray_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{por: 1'b1, xrp: 1'b0, on_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign por_o = st_q.por;
    assign xrp_o = st_q.xrp;
endmodule

// File: rtl/tvreg_slave.sv
module tvreg_slave
    import tvreg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CHIP_ADDR   = 4'h6,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk,
    input  logic              bus_en_n,
    input  logic              bus_dat_i,
    output logic              bus_dat_o,
    output logic              bus_dat_oe_o,
    input  logic              stby_low_i,
    input  logic              xray_trip_i,
    input  logic              hlock_i,
    input  logic [TUNE_W-1:0] fine_tune_i,
    input  logic [SUB_W-1:0]  reg_rd_addr_i,
    output logic [DATA_W-1:0] reg_rd_data_o,
    output logic              hdrv_en_o,
    output logic              pwm_en_o
);
    localparam int SYNC_W = 6;

    typedef struct packed {
        logic [NREGS-1:0][DATA_W-1:0] regs;
    } rf_t;

    logic [SYNC_W-1:0] raw_in, syn_in;
    logic              bclk_s, en_act, din_s, stby_s, xray_s, hlock_s;
    logic              wr_stb, fall_evt, onoff, por_flag, xrp_flag;
    logic [SUB_W-1:0]  wr_sub;
    logic [DATA_W-1:0] wr_data;
    logic [RD_BITS-1:0] reply_word;
    rf_t               rf_d, rf_q;

    assign raw_in = {bus_clk, bus_en_n, bus_dat_i, stby_low_i, xray_trip_i, hlock_i};

    tvreg_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (6'b010000)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    assign bclk_s  = syn_in[5];
    assign en_act  = ~syn_in[4];
    assign din_s   = syn_in[3];
    assign stby_s  = syn_in[2];
    assign xray_s  = syn_in[1];
    assign hlock_s = syn_in[0];

    assign reply_word = {ACK_PATTERN, por_flag, xrp_flag, hlock_s, 1'b0, fine_tune_i};

    tvreg_frame #(
        .CHIP_ADDR (CHIP_ADDR)
    ) frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_act_i  (en_act),
        .bclk_i    (bclk_s),
        .din_i     (din_s),
        .reply_i   (reply_word),
        .wr_stb_o  (wr_stb),
        .wr_sub_o  (wr_sub),
        .wr_data_o (wr_data),
        .dout_o    (bus_dat_o),
        .doe_o     (bus_dat_oe_o),
        .fall_o    (fall_evt)
    );

    always_comb begin
        rf_d = rf_q;
        if (wr_stb) begin
            rf_d.regs[wr_sub] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign onoff         = rf_q.regs[0][0];
    assign reg_rd_data_o = rf_q.regs[reg_rd_addr_i];

    tvreg_status status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .onoff_i (onoff),
        .stby_i  (stby_s),
        .xray_i  (xray_s),
        .por_o   (por_flag),
        .xrp_o   (xrp_flag)
    );

    assign hdrv_en_o = onoff & ~por_flag & ~xrp_flag;
    assign pwm_en_o  = onoff & ~por_flag & ~xrp_flag;
endmodule

// File: rtl/tvreg_slave_chk.sv
module tvreg_slave_chk
    import tvreg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en_act,
    input logic              fall_evt,
    input logic              wr_stb,
    input logic              onoff,
    input logic              stby_s,
    input logic              xray_s,
    input logic              xrp_flag,
    input logic [SUB_W-1:0]  reg_rd_addr_i,
    input logic [DATA_W-1:0] reg_rd_data_o,
    input logic              bus_dat_o,
    input logic              bus_dat_oe_o,
    input logic              hdrv_en_o,
    input logic              pwm_en_o
);
    AST_STBY_KILLS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        stby_s |=> (!hdrv_en_o && !pwm_en_o)); // R7

    AST_XRAY_KILLS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (xray_s && onoff) |=> !hdrv_en_o); // R8

    AST_XRP_CLEAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !onoff |=> !xrp_flag); // R8

    AST_DRIVE_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (hdrv_en_o || pwm_en_o) |-> onoff); // R9

    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dat_oe_o && $past(bus_dat_oe_o) && (bus_dat_o != $past(bus_dat_o)))
        |-> $past(fall_evt)); // R4

    AST_RELEASE_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_act |=> !bus_dat_oe_o); // R5

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> (!$stable(reg_rd_addr_i) || $stable(reg_rd_data_o))); // R1
endmodule

bind tvreg_slave tvreg_slave_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_act        (en_act),
    .fall_evt      (fall_evt),
    .wr_stb        (wr_stb),
    .onoff         (onoff),
    .stby_s        (stby_s),
    .xray_s        (xray_s),
    .xrp_flag      (xrp_flag),
    .reg_rd_addr_i (reg_rd_addr_i),
    .reg_rd_data_o (reg_rd_data_o),
    .bus_dat_o     (bus_dat_o),
    .bus_dat_oe_o  (bus_dat_oe_o),
    .hdrv_en_o     (hdrv_en_o),
    .pwm_en_o      (pwm_en_o)
);

// File: tb/tvreg_slave_tb.sv
`timescale 1ns/1ps
module tvreg_slave_tb_top;
    localparam logic [3:0] ME = 4'h6;
    localparam int HP = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_clk = 1'b0;
    logic       bus_en_n = 1'b1;
    logic       bus_dat_i = 1'b0;
    logic       bus_dat_o, bus_dat_oe_o;
    logic       stby_low_i = 1'b0;
    logic       xray_trip_i = 1'b0;
    logic       hlock_i = 1'b0;
    logic [7:0] fine_tune_i = 8'h5A;
    logic [4:0] reg_rd_addr_i = '0;
    logic [6:0] reg_rd_data_o;
    logic       hdrv_en_o, pwm_en_o;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    tvreg_slave #(.CHIP_ADDR(ME)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_clk       (bus_clk),
        .bus_en_n      (bus_en_n),
        .bus_dat_i     (bus_dat_i),
        .bus_dat_o     (bus_dat_o),
        .bus_dat_oe_o  (bus_dat_oe_o),
        .stby_low_i    (stby_low_i),
        .xray_trip_i   (xray_trip_i),
        .hlock_i       (hlock_i),
        .fine_tune_i   (fine_tune_i),
        .reg_rd_addr_i (reg_rd_addr_i),
        .reg_rd_data_o (reg_rd_data_o),
        .hdrv_en_o     (hdrv_en_o),
        .pwm_en_o      (pwm_en_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] pat(input int s);
        return 7'((s * 19 + 3) & 127);
    endfunction

    // clocks nbits bus cycles (32 = full transaction), then raises enable
    task automatic xfer(input logic [3:0] a, input logic [4:0] s, input logic [6:0] d,
                        input int nbits, output logic [15:0] rep,
                        output bit wr_drove, output bit rd_all);
        logic [15:0] w;
        w = {a, s, d};
        rep = '0;
        wr_drove = 1'b0;
        rd_all = 1'b1;
        bus_en_n = 1'b0;
        bus_clk = 1'b0;
        tick(HP);
        for (int k = 0; k < nbits; k++) begin
            if (k < 16) bus_dat_i = w[15-k];
            tick(HP);
            if (k < 16) begin
                if (bus_dat_oe_o) wr_drove = 1'b1;
            end else begin
                if (!bus_dat_oe_o) rd_all = 1'b0;
                rep[31-k] = bus_dat_o;
            end
            bus_clk = 1'b1;
            tick(HP);
            bus_clk = 1'b0;
        end
        bus_en_n = 1'b1;
        tick(HP);
    endtask

    task automatic status(output logic [15:0] rep);
        bit wd, ra;
        xfer(ME, 5'd31, 7'd0, 32, rep, wd, ra);
    endtask

    task automatic wr0(input logic [6:0] d);
        logic [15:0] r;
        bit wd, ra;
        xfer(ME, 5'd0, d, 32, r, wd, ra);
        tick(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] rep;
        bit wd, ra;

        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R10 reset state
        chk("R10 oe", {15'd0, bus_dat_oe_o}, 16'd0);
        chk("R10 hdrv", {15'd0, hdrv_en_o}, 16'd0);
        chk("R10 pwm", {15'd0, pwm_en_o}, 16'd0);
        reg_rd_addr_i = 5'd0;
        tick(1);
        chk("R6 reset reg", {9'd0, reg_rd_data_o}, 16'd0);

        // R3 R7 reply format after reset: standby flag set
        xfer(ME, 5'd31, 7'd0, 32, rep, wd, ra);
        chk("R3 reply", rep, {4'b1010, 4'b1000, 8'h5A});
        chk("R4 no drive in write", {15'd0, wd}, 16'd0);
        chk("R4 drive whole reply", {15'd0, ra}, 16'd1);
        chk("R4 released after", {15'd0, bus_dat_oe_o}, 16'd0);

        // R1 sweep all indices
        for (int s = 1; s < 32; s++) begin
            xfer(ME, 5'(s), pat(s), 32, rep, wd, ra);
        end
        xfer(ME, 5'd0, 7'h7E, 32, rep, wd, ra);
        for (int s = 0; s < 32; s++) begin
            reg_rd_addr_i = 5'(s);
            tick(1);
            chk("R1 store", {9'd0, reg_rd_data_o}, {9'd0, (s == 0) ? 7'h7E : pat(s)});
        end

        // R2 every other address
        for (int a = 0; a < 16; a++) begin
            if (4'(a) == ME) continue;
            xfer(4'(a), 5'd3, ~pat(3), 32, rep, wd, ra);
            reg_rd_addr_i = 5'd3;
            tick(1);
            chk("R2 no write", {9'd0, reg_rd_data_o}, {9'd0, pat(3)});
            chk("R2 no drive", {14'd0, wd, ra & 1'b0}, 16'd0);
            total++;
            if (ra) begin
                fails++;
                $display("FAIL R2 drove reply actual=1 expected=0");
            end
        end

        // R3 fine-tune byte patterns and lock bit
        foreach (rep[i]) begin end
        for (int v = 0; v < 4; v++) begin
            fine_tune_i = (v == 0) ? 8'h00 : (v == 1) ? 8'hFF : (v == 2) ? 8'hA5 : 8'h3C;
            hlock_i = v[0];
            tick(4);
            status(rep);
            chk("R3 tune byte", {8'd0, rep[7:0]}, {8'd0, fine_tune_i});
            chk("R3 lock bit", {15'd0, rep[9]}, {15'd0, v[0]});
            chk("R3 ack", {12'd0, rep[15:12]}, 16'hA);
            chk("R3 s3 zero", {15'd0, rep[8]}, 16'd0);
        end
        hlock_i = 1'b0;

        // R7 R9 turn on clears standby flag
        wr0(7'h01);
        chk("R9 hdrv on", {15'd0, hdrv_en_o}, 16'd1);
        chk("R9 pwm on", {15'd0, pwm_en_o}, 16'd1);
        status(rep);
        chk("R7 cleared by on", {14'd0, rep[11:10]}, 16'd0);

        // R8 x-ray latch
        xray_trip_i = 1'b1; tick(3); xray_trip_i = 1'b0; tick(5);
        chk("R8 hdrv off", {15'd0, hdrv_en_o}, 16'd0);
        chk("R9 pwm off", {15'd0, pwm_en_o}, 16'd0);
        status(rep);
        chk("R8 latched", {15'd0, rep[10]}, 16'd1);
        wr0(7'h01);
        chk("R8 on again no clear", {15'd0, hdrv_en_o}, 16'd0);
        wr0(7'h00);
        status(rep);
        chk("R8 cleared by off", {15'd0, rep[10]}, 16'd0);
        xray_trip_i = 1'b1; tick(3); xray_trip_i = 1'b0; tick(5);
        status(rep);
        chk("R8 blocked while off", {15'd0, rep[10]}, 16'd0);
        wr0(7'h01);
        chk("R9 back on", {15'd0, hdrv_en_o}, 16'd1);

        // R7 standby flag
        stby_low_i = 1'b1; tick(3); stby_low_i = 1'b0; tick(5);
        chk("R7 hdrv off", {15'd0, hdrv_en_o}, 16'd0);
        wr0(7'h01);
        status(rep);
        chk("R7 held without transition", {15'd0, rep[11]}, 16'd1);
        stby_low_i = 1'b1; tick(4);
        wr0(7'h00);
        wr0(7'h01);
        chk("R7 low during on", {15'd0, hdrv_en_o}, 16'd0);
        status(rep);
        chk("R7 set wins", {15'd0, rep[11]}, 16'd1);
        stby_low_i = 1'b0; tick(4);
        wr0(7'h00);
        wr0(7'h01);
        chk("R7 restart", {15'd0, hdrv_en_o}, 16'd1);
        chk("R9 restart pwm", {15'd0, pwm_en_o}, 16'd1);

        // R5 abort in command phase
        xfer(ME, 5'd9, 7'h00, 12, rep, wd, ra);
        reg_rd_addr_i = 5'd9;
        tick(1);
        chk("R5 partial discarded", {9'd0, reg_rd_data_o}, {9'd0, pat(9)});
        xfer(ME, 5'd9, 7'h00, 15, rep, wd, ra);
        tick(1);
        chk("R5 15 bits discarded", {9'd0, reg_rd_data_o}, {9'd0, pat(9)});
        // R5 abort in reply phase: write kept, line released
        bus_en_n = 1'b0; tick(HP);
        for (int k = 0; k < 20; k++) begin
            if (k < 16) bus_dat_i = (k < 4) ? ME[3-k] : (k < 9) ? 1'(5'd9 >> (8-k)) : 1'(7'h11 >> (15-k));
            tick(HP);
            bus_clk = 1'b1;
            tick(HP);
            bus_clk = 1'b0;
        end
        tick(HP);
        chk("R4 driving mid reply", {15'd0, bus_dat_oe_o}, 16'd1);
        bus_en_n = 1'b1;
        tick(4);
        chk("R5 released", {15'd0, bus_dat_oe_o}, 16'd0);
        chk("R1 kept after full command", {9'd0, reg_rd_data_o}, 16'h11);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule